// File: doc/BRIEF.md
# Pointer-Indexed SPI Register Slave

This block is an SPI slave that works in 16-bit frames. Its internal byte registers are reached only through an 8-bit pointer. One command loads the pointer and another reads it back. A data-write command stores its payload byte at the register the pointer selects, and a data-read command returns that register. A sixth command returns a 14-bit sample word taken from a side input port. Every frame carries an odd parity bit. The reply to a frame is not sent during that frame: it is shifted out on MISO during the following frame.

After reset the block is locked. Until one exact unlock frame arrives, every other frame is discarded and earns an all-zero reply. Once unlocked, a frame with bad parity earns a fixed fault word, and an unknown command earns a fixed invalid word. SCLK, CS and MOSI are sampled by the system clock through synchronizers, so SCLK must run well below the system clock rate. A register write commits in the system clock cycle after the end of the frame is detected, never partway through a frame.

Top module: `ptr_spi_slave`

## Requirements
- R1: A frame is 16 bits, sent MSB first, in SPI mode 0: MOSI is sampled on SCLK rising, MISO changes on SCLK falling, and CS is active low. Field layout: bits 15:12 are the opcode, bits 11:9 are reserved and must be zero, bit 8 is parity, and bits 7:0 are the payload.
- R2: Parity is odd over all 16 bits. While unlocked, a frame with even parity changes neither the pointer nor the registers, and its reply is 16'h81FF.
- R3: After reset the block is locked. While locked, every frame except the unlock frame has no effect and its reply is 16'h0000.
- R4: The unlock frame has opcode 4'hA, reserved bits zero, payload 8'hC3 and good parity. It unlocks the block, and its reply is 16'hA0C3.
- R5: Pointer write (opcode 4'h1) loads the pointer with the payload. Its reply is {8'h10, payload}.
- R6: Pointer read (opcode 4'h2) replies {8'h20, pointer}. The pointer resets to 8'h00.
- R7: Data write (opcode 4'h3) stores the payload at the register the pointer selects, in the cycle after the frame end is detected. Its reply is {8'h30, pointer}. A pointer at or beyond NREGS makes the write have no effect.
- R8: Data read (opcode 4'h4) replies {8'h40, register[pointer]}. Registers reset to 8'h00, and a pointer at or beyond NREGS reads as 8'h00.
- R9: Sample read (opcode 5) replies {2'b01, sample[13:0]}, using the sample value present when the frame ends.
- R10: While unlocked, a frame with good parity that has another opcode or nonzero reserved bits has no effect, and its reply is 16'h7E00.
- R11: The reply to a frame is shifted out during the next frame. The reply pending after reset is 16'h0000.
- R12: A frame in which CS rises after any number of SCLK rising edges other than 16 is dropped. It has no effect, and the pending reply stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial reply data to the master |
| sample | input | 14 | Sample word returned by the sample-read command |

## Verification
The register write commit and the loading of the next frame's reply both happen at a frame boundary. When a data write is followed at once by a data read, the commit must land before the read frame is decoded. The bench sends write-then-read pairs with the shortest CS-high gap it uses and with a random pointer, some in range and some out. Each read reply is compared with a bench model that applies the write first.

// File: rtl/pspi_pkg.sv
package pspi_pkg;
    localparam int FRAME_W  = 16;
    localparam int CNT_W    = 5;
    localparam int SAMPLE_W = 14;

    localparam logic [3:0] OP_PTR_WR = 4'h1;
    localparam logic [3:0] OP_PTR_RD = 4'h2;
    localparam logic [3:0] OP_DAT_WR = 4'h3;
    localparam logic [3:0] OP_DAT_RD = 4'h4;
    localparam logic [3:0] OP_SMP_RD = 4'h5;
    localparam logic [3:0] OP_UNLOCK = 4'hA;

    localparam logic [7:0]  UNLOCK_KEY   = 8'hC3;
    localparam logic [15:0] FAULT_WORD   = 16'h81FF;
    localparam logic [15:0] INVALID_WORD = 16'h7E00;

    typedef struct packed {
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
        logic [7:0]         ptr;
        logic [FRAME_W-1:0] pend;
        logic               unlocked;
    } slv_state_t;
endpackage

// File: rtl/pspi_sync.sv
module pspi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic dprev
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout  = chain_q[STAGES-1];
    assign dprev = chain_q[STAGES];
endmodule

// File: rtl/pspi_regfile.sv
module pspi_regfile #(
    parameter int NREGS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       hit
);
    localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [NREGS-1:0][7:0] mem_d, mem_q;
    logic [IDXW-1:0]       idx;

    assign hit = (int'(addr) < NREGS);
    assign idx = addr[IDXW-1:0];

    always_comb begin
        mem_d = mem_q;
        if (we && hit) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = hit ? mem_q[idx] : 8'h00;

    // R7
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> (mem_q[$past(idx)] == $past(wdata)));
    // R7
    wr_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> $stable(mem_q));
endmodule

// File: rtl/pspi_decode.sv
module pspi_decode
    import pspi_pkg::*;
(
    input  logic [FRAME_W-1:0]  frame,
    input  logic                unlocked,
    input  logic [7:0]          ptr,
    input  logic [7:0]          rdata,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [FRAME_W-1:0]  resp,
    output logic                unlock_nxt,
    output logic                ptr_we,
    output logic                reg_we
);
    logic [3:0] op;
    logic [2:0] rsv;
    logic [7:0] pay;
    logic       par_ok;
    logic       is_key;

    assign op     = frame[15:12];
    assign rsv    = frame[11:9];
    assign pay    = frame[7:0];
    assign par_ok = ^frame;
    assign is_key = par_ok && (op == OP_UNLOCK) && (rsv == 3'b000) && (pay == UNLOCK_KEY);

    always_comb begin
        resp       = '0;
        unlock_nxt = unlocked;
        ptr_we     = 1'b0;
        reg_we     = 1'b0;
        if (!unlocked) begin
            if (is_key) begin
                unlock_nxt = 1'b1;
                resp       = {OP_UNLOCK, 4'h0, UNLOCK_KEY};
            end
        end else if (!par_ok) begin
            resp = FAULT_WORD;
        end else if (rsv != 3'b000) begin
            resp = INVALID_WORD;
        end else begin
            case (op)
                OP_PTR_WR: begin
                    ptr_we = 1'b1;
                    resp   = {8'h10, pay};
                end
                OP_PTR_RD: resp = {8'h20, ptr};
                OP_DAT_WR: begin
                    reg_we = 1'b1;
                    resp   = {8'h30, ptr};
                end
                OP_DAT_RD: resp = {8'h40, rdata};
                OP_SMP_RD: resp = {2'b01, sample};
                OP_UNLOCK: resp = is_key ? {OP_UNLOCK, 4'h0, UNLOCK_KEY} : INVALID_WORD;
                default:   resp = INVALID_WORD;
            endcase
        end
    end
endmodule

// File: rtl/ptr_spi_slave.sv
module ptr_spi_slave
    import pspi_pkg::*;
#(
    parameter int NREGS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_cs_n,
    input  logic                spi_sclk,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [SAMPLE_W-1:0] sample
);
    localparam int         NLINES  = 3;
    localparam logic [2:0] LINE_RV = 3'b001;

    logic [NLINES-1:0] line_in, line_now, line_old;
    assign line_in = {spi_mosi, spi_sclk, spi_cs_n};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        pspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RV[g])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_in[g]),
            .dout (line_now[g]),
            .dprev(line_old[g])
        );
    end

    logic cs_fall, cs_rise, sclk_rise, sclk_fall, mosi_s, active;
    assign cs_fall   =  line_old[0] && !line_now[0];
    assign cs_rise   = !line_old[0] &&  line_now[0];
    assign sclk_rise = !line_old[1] &&  line_now[1];
    assign sclk_fall =  line_old[1] && !line_now[1];
    assign mosi_s    =  line_now[2];
    assign active    = !line_now[0];

    slv_state_t st_d, st_q;

    logic               frame_done;
    logic [FRAME_W-1:0] dec_resp;
    logic               dec_unlock, dec_ptr_we, dec_reg_we;
    logic [7:0]         rf_rdata;
    logic               rf_hit;

    assign frame_done = cs_rise && (st_q.cnt == CNT_W'(FRAME_W));

    pspi_regfile #(.NREGS(NREGS)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (frame_done && dec_reg_we),
        .addr (st_q.ptr),
        .wdata(st_q.rx[7:0]),
        .rdata(rf_rdata),
        .hit  (rf_hit)
    );

    pspi_decode u_dec (
        .frame     (st_q.rx),
        .unlocked  (st_q.unlocked),
        .ptr       (st_q.ptr),
        .rdata     (rf_rdata),
        .sample    (sample),
        .resp      (dec_resp),
        .unlock_nxt(dec_unlock),
        .ptr_we    (dec_ptr_we),
        .reg_we    (dec_reg_we)
    );

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.cnt = '0;
            st_d.tx  = st_q.pend;
        end else if (active) begin
            if (sclk_rise) begin
                st_d.rx = {st_q.rx[FRAME_W-2:0], mosi_s};
                if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_fall) st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
        end
        if (frame_done) begin
            st_d.pend     = dec_resp;
            st_d.unlocked = dec_unlock;
            if (dec_ptr_we) st_d.ptr = st_q.rx[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso = st_q.tx[FRAME_W-1];

    // R11
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (st_q.tx == $past(st_q.pend)));
    // R12
    short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && st_q.cnt != CNT_W'(FRAME_W)) |=> ($stable(st_q.pend) && $stable(st_q.ptr) && $stable(st_q.unlocked)));
    // R2
    parity_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && st_q.unlocked && !(^st_q.rx)) |=> (st_q.pend == FAULT_WORD && $stable(st_q.ptr)));
    // R3
    locked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !st_q.unlocked && st_q.rx[15:12] != OP_UNLOCK) |=> (st_q.pend == '0 && !st_q.unlocked));
    // R3
    locked_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !st_q.unlocked) |-> !dec_reg_we && !dec_ptr_we);
    // R4
    stay_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unlocked |=> st_q.unlocked);
endmodule

// File: tb/ptr_spi_slave_bench.sv
module ptr_spi_slave_bench;
    localparam int NREGS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [13:0] sample = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ptr_spi_slave #(.NREGS(NREGS), .SYNC_STAGES(2)) u_ptr_spi_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_cs_n(cs_n),
        .spi_sclk(sclk),
        .spi_mosi(mosi),
        .spi_miso(miso),
        .sample  (sample)
    );

    // reference model state
    bit          m_unl = 0;
    logic [7:0]  m_ptr = '0;
    logic [7:0]  m_regs [NREGS];
    logic [15:0] m_pend = '0;
    string       m_tag = "R11";

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] rsv, input logic [7:0] pay);
        logic [15:0] f;
        f = {op, rsv, 1'b0, pay};
        f[8] = ~(^f);
        return f;
    endfunction

    task automatic model(input logic [15:0] f);
        logic [7:0] rd;
        if (!m_unl) begin
            if ((^f) && f[15:12] == 4'hA && f[11:9] == 3'b0 && f[7:0] == 8'hC3) begin
                m_unl = 1; m_pend = 16'hA0C3; m_tag = "R4";
            end else begin
                m_pend = 16'h0000; m_tag = "R3";
            end
        end else if (!(^f)) begin
            m_pend = 16'h81FF; m_tag = "R2";
        end else if (f[11:9] != 3'b0) begin
            m_pend = 16'h7E00; m_tag = "R10";
        end else begin
            case (f[15:12])
                4'h1: begin m_ptr = f[7:0]; m_pend = {8'h10, f[7:0]}; m_tag = "R5"; end
                4'h2: begin m_pend = {8'h20, m_ptr}; m_tag = "R6"; end
                4'h3: begin
                    if (int'(m_ptr) < NREGS) m_regs[m_ptr[3:0]] = f[7:0];
                    m_pend = {8'h30, m_ptr}; m_tag = "R7";
                end
                4'h4: begin
                    rd = (int'(m_ptr) < NREGS) ? m_regs[m_ptr[3:0]] : 8'h00;
                    m_pend = {8'h40, rd}; m_tag = "R8";
                end
                4'h5: begin m_pend = {2'b01, sample}; m_tag = "R9"; end
                4'hA: begin
                    m_pend = (f[7:0] == 8'hC3) ? 16'hA0C3 : 16'h7E00;
                    m_tag = (f[7:0] == 8'hC3) ? "R4" : "R10";
                end
                default: begin m_pend = 16'h7E00; m_tag = "R10"; end
            endcase
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // mode 0 transfer of nbits; bits beyond 16 are zero
    task automatic xfer(input logic [15:0] f, input int nbits, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? f[15-i] : 1'b0;
            wait_clk(8);
            if (i < 16) got[15-i] = miso;
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
        end
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic run(input logic [15:0] f);
        logic [15:0] got, exp;
        string tag;
        exp = m_pend; tag = m_tag;
        xfer(f, 16, got);
        chk(tag, got, exp);
        model(f);
    endtask

    task automatic run_bad_len(input logic [15:0] f, input int nbits);
        logic [15:0] got;
        xfer(f, nbits, got);
    endtask

    initial begin
        int limit;
        limit = 0;
        while (!done) begin
            @(posedge clk);
            limit++;
            if (limit > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", limit, 190000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [3:0] op;
        logic [15:0] f;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < NREGS; i++) m_regs[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R11: reset state of MISO
        chk("R11", {15'b0, miso}, 16'h0000);

        // R3: locked, commands ignored
        run(mk(4'h1, 3'b0, 8'h07));
        run(mk(4'h3, 3'b0, 8'hEE));
        run(mk(4'hA, 3'b0, 8'hC3) ^ 16'h0001);   // unlock key with bad parity
        run(mk(4'hA, 3'b0, 8'hC2));              // wrong key
        // R4: unlock
        run(mk(4'hA, 3'b0, 8'hC3));
        // R6: pointer reset value, not touched while locked
        run(mk(4'h2, 3'b0, 8'h00));
        // R8: register not touched while locked
        run(mk(4'h4, 3'b0, 8'h00));
        // R5, R6, R7, R8 back to back
        run(mk(4'h1, 3'b0, 8'h05));
        run(mk(4'h2, 3'b0, 8'h00));
        run(mk(4'h3, 3'b0, 8'h3C));
        run(mk(4'h4, 3'b0, 8'h00));
        // R2: bad parity write has no effect
        run(mk(4'h3, 3'b0, 8'h99) ^ 16'h0100);
        run(mk(4'h4, 3'b0, 8'h00));
        run(mk(4'h1, 3'b0, 8'h09) ^ 16'h0001);
        run(mk(4'h2, 3'b0, 8'h00));
        // R12: short and long frames dropped
        run_bad_len(mk(4'h3, 3'b0, 8'h99), 8);
        run(mk(4'h4, 3'b0, 8'h00));
        run_bad_len(mk(4'h1, 3'b0, 8'h0A), 17);
        run(mk(4'h2, 3'b0, 8'h00));
        // R7, R8: pointer beyond register count
        run(mk(4'h1, 3'b0, 8'h20));
        run(mk(4'h3, 3'b0, 8'h77));
        run(mk(4'h4, 3'b0, 8'h00));
        run(mk(4'h1, 3'b0, 8'h0F));
        run(mk(4'h3, 3'b0, 8'hA5));
        run(mk(4'h4, 3'b0, 8'h00));
        // R10: invalid opcode and reserved bits
        run(mk(4'h7, 3'b0, 8'h12));
        run(mk(4'h1, 3'b010, 8'h03));
        run(mk(4'h2, 3'b0, 8'h00));
        // R9: sample read
        sample = 14'h2ABC;
        run(mk(4'h5, 3'b0, 8'h00));
        sample = 14'h0155;
        run(mk(4'h5, 3'b0, 8'h00));

        // R1: constrained random traffic
        for (int n = 0; n < 140; n++) begin
            sample = 14'($urandom);
            case ($urandom % 10)
                0, 1: op = 4'h3;
                2, 3: op = 4'h4;
                4:    op = 4'h1;
                5:    op = 4'h2;
                6:    op = 4'h5;
                7:    op = 4'($urandom);
                default: op = 4'h4;
            endcase
            if (op == 4'h1) f = mk(op, 3'b0, 8'($urandom % 20));
            else            f = mk(op, ($urandom % 12 == 0) ? 3'b001 : 3'b000, 8'($urandom));
            if ($urandom % 15 == 0) f = f ^ 16'h0040;
            run(f);
        end
        run(mk(4'h2, 3'b0, 8'h00));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule